// File: doc/BRIEF.md
# Slot Card Host Port Decoder

This block sits on a plug-in card and decodes an 8-bit parallel host port shared by every slot on the backplane. The host presents an address, a read/write level and an active-low enable, and it exchanges bytes over a bidirectional data bus. The card holds its own slot number in a 4-bit latch that is loaded from a strap input. An access belongs to the card only when the address's upper nibble equals that latched number. Only the three lowest address bits select a byte in an eight-byte local register file. That register file stands in for the local device.

All host inputs are sampled on the card clock, so the card sees them one cycle late. A matched read puts the addressed byte on the data bus while the enable stays low. A matched write is committed when the enable is released, using the last address and data sampled during the enable period. The card raises a service request toward the host while bit 0 of the byte at index 7 is set. It drives its card-present line low once it is out of reset and releases it while in reset.

Top module: `hp_host_port`

## Requirements
- R1: While reset is asserted, card_present_oe_o is 0, host_req_o is 0 and the data bus is released. From the second clock after reset is released, card_present_oe_o is 1 and card_present_o is 0. After reset, every register byte reads 0.
- R2: A one-cycle pulse on card_id_load_i stores card_id_i. The stored number then holds until the next pulse, whatever card_id_i does in between.
- R3: When host_addr_i[7:4] equals the stored number, host_rw_i is 1 and host_en_ni is 0, the card drives the byte at index host_addr_i[2:0] onto host_data_io. The byte is valid from the second falling clock edge after the enable goes low.
- R4: When the upper nibble does not match, the card never drives host_data_io, and a write does not change any register.
- R5: A matched write (host_rw_i 0) changes the addressed byte only after host_en_ni returns high. Reading the byte afterwards returns the written value.
- R6: Address bit 3 plays no part in the decode. Indices n and n+8 within the nibble reach the same byte.
- R7: A read access leaves every register byte unchanged.
- R8: host_req_o equals bit 0 of the byte at index 7.
- R9: When the address or data changes while the enable is held low, the write uses the last values sampled before the enable rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 8 | Host address: [7:4] slot select, [2:0] register index |
| host_data_io | inout | 8 | Bidirectional host data bus |
| host_en_ni | input | 1 | Host bus enable, active low |
| host_rw_i | input | 1 | 1 = read, 0 = write |
| card_id_i | input | 4 | Slot number strap |
| card_id_load_i | input | 1 | Load pulse for the slot number latch |
| host_req_o | output | 1 | Service request toward the host |
| card_present_o | output | 1 | Card-present data, always 0 (open-collector) |
| card_present_oe_o | output | 1 | Card-present pull-down enable |

## Verification
Random accesses mix addresses whose upper nibble equals the stored number with addresses whose nibble is random. This separates a decoder that compares the nibble from one that ignores it or compares the wrong bits. Random values in address bit 3 show whether that bit leaks into the index. Directed cases include:
- a read on a mismatched nibble while the bench drives the bus itself, which exposes any unwanted drive;
- a write whose data changes during the enable, which distinguishes last-sampled capture from first-sampled capture;
- a reload of the slot number after which the old nibble must no longer hit;
- writes to bit 0 of index 7, which track the request line.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned ID_W   = 4;
  localparam int unsigned ID_LSB = ADDR_W - ID_W;
  localparam int unsigned NREGS  = 1 << IDX_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              rd;
  } hp_access_t;
endpackage

// File: rtl/hp_id_latch.sv
module hp_id_latch #(
  parameter int unsigned ID_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] id_i,
  input  logic            load_i,
  output logic [ID_W-1:0] id_o
);
  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     id_q <= '0;
    else if (load_i) id_q <= id_i;
  end

  assign id_o = id_q;

  assert_id_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(id_o));
  assert_id_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> id_o == $past(id_i));
endmodule

// File: rtl/hp_decode.sv
module hp_decode
  import hp_pkg::*;
#(
  parameter int unsigned A_W   = ADDR_W,
  parameter int unsigned D_W   = DATA_W,
  parameter int unsigned I_W   = IDX_W,
  parameter int unsigned C_W   = ID_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] addr_i,
  input  logic [D_W-1:0] data_i,
  input  logic           en_ni,
  input  logic           rw_i,
  input  logic [C_W-1:0] card_id_i,
  output logic           rd_drive_o,
  output logic [I_W-1:0] rd_idx_o,
  output logic           wr_en_o,
  output logic [I_W-1:0] wr_idx_o,
  output logic [D_W-1:0] wr_data_o
);
  localparam int unsigned SEL_LSB = A_W - C_W;
  localparam int unsigned GAP_W   = SEL_LSB - I_W;

  hp_access_t smp_q, hold_q;
  logic       en_q, en_d1_q;
  logic       smp_hit, hold_hit;

  // input sampling stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q   <= '0;
      en_q    <= 1'b0;
      en_d1_q <= 1'b0;
    end else begin
      smp_q.addr <= addr_i;
      smp_q.data <= data_i;
      smp_q.rd   <= rw_i;
      en_q       <= ~en_ni;
      en_d1_q    <= en_q;
    end
  end

  // last access seen while enabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (en_q) hold_q <= smp_q;
  end

  assign smp_hit  = smp_q.addr[A_W-1:SEL_LSB] == card_id_i;
  assign hold_hit = hold_q.addr[A_W-1:SEL_LSB] == card_id_i;

  assign rd_drive_o = en_q & smp_q.rd & smp_hit;
  assign rd_idx_o   = smp_q.addr[I_W-1:0];

  assign wr_en_o   = en_d1_q & ~en_q & ~hold_q.rd & hold_hit;
  assign wr_idx_o  = hold_q.addr[I_W-1:0];
  assign wr_data_o = hold_q.data;

  // bits between index and slot select do not decode
  generate
    if (GAP_W > 0) begin : g_gap
      logic [GAP_W-1:0] gap_unused;
      assign gap_unused = smp_q.addr[SEL_LSB-1:I_W] ^ hold_q.addr[SEL_LSB-1:I_W];
    end
  endgenerate
endmodule

// File: rtl/hp_regfile.sv
module hp_regfile #(
  parameter int unsigned I_W     = 3,
  parameter int unsigned D_W     = 8,
  parameter int unsigned REQ_IDX = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [I_W-1:0] wr_idx_i,
  input  logic [D_W-1:0] wr_data_i,
  input  logic [I_W-1:0] rd_idx_i,
  output logic [D_W-1:0] rd_data_o,
  output logic           req_o
);
  localparam int unsigned NR = 1 << I_W;
  localparam logic [I_W-1:0] REQ_SEL = I_W'(REQ_IDX);

  logic [NR-1:0][D_W-1:0] regs_q;

  generate
    for (genvar g = 0; g < NR; g++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   regs_q[g] <= '0;
        else if (wr_en_i && wr_idx_i == I_W'(g))       regs_q[g] <= wr_data_i;
      end
    end
  endgenerate

  assign rd_data_o = regs_q[rd_idx_i];
  assign req_o     = regs_q[REQ_SEL][0];

  assert_regs_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_q));
  assert_req_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == REQ_SEL) |=> req_o == $past(wr_data_i[0]));
endmodule

// File: rtl/hp_host_port.sv
module hp_host_port
  import hp_pkg::*;
#(
  parameter int unsigned REQ_IDX = NREGS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  inout  wire  [DATA_W-1:0] host_data_io,
  input  logic              host_en_ni,
  input  logic              host_rw_i,
  input  logic [ID_W-1:0]   card_id_i,
  input  logic              card_id_load_i,
  output logic              host_req_o,
  output logic              card_present_o,
  output logic              card_present_oe_o
);
  logic [ID_W-1:0]   card_id;
  logic              rd_drive, wr_en;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [1:0]        present_q;

  hp_id_latch #(.ID_W(ID_W)) i_id (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .id_i   (card_id_i),
    .load_i (card_id_load_i),
    .id_o   (card_id)
  );

  hp_decode i_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (host_addr_i),
    .data_i     (host_data_io),
    .en_ni      (host_en_ni),
    .rw_i       (host_rw_i),
    .card_id_i  (card_id),
    .rd_drive_o (rd_drive),
    .rd_idx_o   (rd_idx),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  hp_regfile #(.I_W(IDX_W), .D_W(DATA_W), .REQ_IDX(REQ_IDX)) i_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .req_o     (host_req_o)
  );

  assign host_data_io = rd_drive ? rd_data : {DATA_W{1'bz}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) present_q <= '0;
    else         present_q <= {present_q[0], 1'b1};
  end

  assign card_present_oe_o = present_q[1];
  assign card_present_o    = 1'b0;

  assert_present_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_present_oe_o |=> card_present_oe_o);
  assert_drive_needs_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_drive |-> (!$past(host_en_ni) && $past(host_rw_i)));
  assert_no_drive_unmatched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_drive |-> $past(host_addr_i[ADDR_W-1:ID_LSB]) == card_id);
  assert_write_after_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> ($past(host_en_ni) && !$past(host_en_ni, 2) && !$past(host_rw_i, 2)));
endmodule

// File: tb/test_hp_host_port.sv
`timescale 1ns/1ps
module test_hp_host_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       en_n = 1'b1;
  logic       rw = 1'b1;
  logic [3:0] id_in = '0;
  logic       id_ld = 1'b0;
  logic       tb_oe = 1'b0;
  logic [7:0] tb_dat = '0;
  wire  [7:0] bus;
  logic       req, pres, pres_oe;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_regs [8];
  logic [3:0] exp_id = '0;

  always #2.5 clk = ~clk;

  assign bus = tb_oe ? tb_dat : 8'bz;

  hp_host_port i_hp_host_port (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_data_io(bus),
    .host_en_ni(en_n), .host_rw_i(rw), .card_id_i(id_in), .card_id_load_i(id_ld),
    .host_req_o(req), .card_present_o(pres), .card_present_oe_o(pres_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic hits(input logic [7:0] a);
    return a[7:4] == exp_id;
  endfunction

  task automatic load_id(input logic [3:0] v);
    @(negedge clk); id_in = v; id_ld = 1'b1;
    @(negedge clk); id_ld = 1'b0; id_in = ~v;
    exp_id = v;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; tb_dat = d; tb_oe = 1'b1; rw = 1'b0; en_n = 1'b0;
    repeat (2) @(negedge clk);
    en_n = 1'b1; rw = 1'b1; tb_oe = 1'b0;
    repeat (2) @(negedge clk);
    if (hits(a)) exp_regs[a[2:0]] = d;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rw = 1'b1; tb_oe = 1'b0; en_n = 1'b0;
    repeat (2) @(negedge clk);
    v = bus;
    en_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // read on a foreign nibble while the bench drives the bus itself
  task automatic foreign_read(input logic [7:0] a, input logic [7:0] d, output logic [7:0] v);
    @(negedge clk); addr = a; rw = 1'b1; tb_dat = d; tb_oe = 1'b1; en_n = 1'b0;
    repeat (2) @(negedge clk);
    v = bus;
    en_n = 1'b1;
    @(negedge clk); tb_oe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, a, d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) exp_regs[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 present_oe in reset", {7'd0, pres_oe}, 8'd0);
    check("R1 req in reset", {7'd0, req}, 8'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 present_oe after reset", {7'd0, pres_oe}, 8'd1);
    check("R1 present data", {7'd0, pres}, 8'd0);
    for (int i = 0; i < 8; i++) begin
      host_read({4'd0, 4'(i)}, v);
      check("R1 reg reset value", v, 8'd0);
    end

    // R2: load id, strap changes afterwards
    load_id(4'h5);
    host_write(8'h52, 8'hC3);
    host_read(8'h52, v);
    check("R2/R3 read after id load", v, 8'hC3);

    // R4: foreign nibble write and read
    host_write(8'h62, 8'h11);
    host_read(8'h52, v);
    check("R4 foreign write ignored", v, 8'hC3);
    foreign_read(8'h61, 8'h3C, v);
    check("R4 no drive on foreign read", v, 8'h3C);

    // R6: bit 3 aliasing
    host_write(8'h5B, 8'h9E);
    host_read(8'h53, v);
    check("R6 alias n+8 to n", v, 8'h9E);
    host_read(8'h5B, v);
    check("R6 alias read", v, 8'h9E);

    // R5: no commit while enable held low
    @(negedge clk); addr = 8'h54; tb_dat = 8'h77; tb_oe = 1'b1; rw = 1'b0; en_n = 1'b0;
    repeat (4) @(negedge clk);
    // R9: data and address change during enable
    addr = 8'h55; tb_dat = 8'hA6;
    repeat (2) @(negedge clk);
    en_n = 1'b1; rw = 1'b1; tb_oe = 1'b0;
    repeat (2) @(negedge clk);
    exp_regs[5] = 8'hA6;
    host_read(8'h54, v);
    check("R9 early address not written", v, 8'h00);
    host_read(8'h55, v);
    check("R9 last sampled written", v, 8'hA6);

    // R8: request line
    host_write(8'h57, 8'h01);
    check("R8 req set", {7'd0, req}, 8'd1);
    host_write(8'h5F, 8'hFE);
    check("R8 req clear via alias", {7'd0, req}, 8'd0);

    // R7: reads leave contents
    host_read(8'h55, v);
    host_read(8'h55, v);
    check("R7 repeated read", v, 8'hA6);

    // R2: reload, old nibble no longer hits
    load_id(4'hA);
    host_write(8'h55, 8'h00);
    host_read(8'hA5, v);
    check("R2 reload keeps contents, old nibble dead", v, 8'hA6);

    // random mix
    for (int k = 0; k < 400; k++) begin
      a = ($urandom % 2) ? {exp_id, 4'($urandom)} : 8'($urandom);
      d = 8'($urandom);
      if ($urandom % 2) begin
        host_write(a, d);
        check("R8 req tracks byte 7", {7'd0, req}, {7'd0, exp_regs[7][0]});
      end else if (hits(a)) begin
        host_read(a, v);
        check("R3 random read", v, exp_regs[a[2:0]]);
      end else begin
        foreign_read(a, d, v);
        check("R4 random foreign read", v, d);
      end
    end
    for (int i = 0; i < 8; i++) begin
      host_read({exp_id, 4'(i + 8)}, v);
      check("R5 final contents", v, exp_regs[i]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule